// File: doc/BRIEF.md
# Clock-Independent Latching Interrupt Bank

This block watches a set of level-sensitive event inputs, such as power-fail or shutdown indications, and records each one in a capture cell whose set path is asynchronous. The cell is set by the input reaching its active level, so an event is kept even if the register-bus clock is gated at that moment. Software sees the captured state through a small register window. It can enable each channel, read raw and masked status, release captures by writing ones, and choose per channel whether the active level is high or low.

Each channel's active level is the input XOR its polarity bit. The capture state is brought into the bus clock domain by a two-stage synchroniser and then shown as raw status. Masked status is raw status gated by the enable bits. A single interrupt line is the OR of all masked bits. A release that is written while the input is still active sets the capture again as soon as the release pulse ends. Only level detection exists, and the mode register reports that as a constant.

Top module: `latch_irq_bank`

## Requirements
- R1: After reset the enable and polarity registers read 0 and irq_o is low. With every input low, raw and masked status read 0.
- R2: With polarity bit 0, a channel whose input goes high is captured. The capture stays set after the input returns low.
- R3: With polarity bit 1, a channel is captured when its input is low. A later high input does not release the capture.
- R4: An input pulse that arrives and ends while the bus clock is stopped is still captured. It shows in raw status once the clock runs again.
- R5: Writing the release register at offset 0x0C releases each channel whose wdata bit is 1. Channels whose bit is 0 keep their capture, and enable and polarity do not change.
- R6: If a channel's input is still active when its release is written, the capture sets again. It stays set after the input later goes inactive.
- R7: A capture becomes visible in raw status on the second rising clock edge after the input turns active, and not before.
- R8: Masked status at offset 0x08 reads raw status AND enable.
- R9: irq_o is high exactly when any masked status bit is 1.
- R10: The mode register at offset 0x14 reads all ones (level mode) on every channel. Writes to mode, raw status (0x04) and masked status (0x08) have no effect.
- R11: Enable at 0x00 and polarity at 0x10 read back the last value written. Bit i of each register belongs to channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register-bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | NUM_CH | Write data, one bit per channel |
| rdata_o | output | NUM_CH | Read data for addr_i, same cycle |
| evt_i | input | NUM_CH | Level event inputs, may be asynchronous |
| irq_o | output | 1 | Combined interrupt, OR of masked status |

## Verification
The bench builds the block with its defaults: eight channels and a five-bit offset. That makes the full 0x00..0x14 window and every channel addressable. The default width lets one write carry mixed release patterns across channels, such as one bit set next to a still-latched neighbour. The bench also stops its own clock to show a capture made with no edges at all. It counts negative edges after an input change to find the exact cycle in which the two-stage synchroniser first shows the capture.

// File: rtl/lirq_pkg.sv
`timescale 1ns/1ps
package lirq_pkg;
  localparam int OFF_EN   = 'h00;
  localparam int OFF_RAW  = 'h04;
  localparam int OFF_MSK  = 'h08;
  localparam int OFF_CLR  = 'h0C;
  localparam int OFF_POL  = 'h10;
  localparam int OFF_MODE = 'h14;
endpackage

// File: rtl/lirq_catch_cell.sv
`timescale 1ns/1ps
// Capture flop clocked by the event itself; release is an async reset.
module lirq_catch_cell (
  input  logic act_i,
  input  logic clr_i,
  output logic status_o
);
  logic hit_q;
  logic trig;

  // Gating with clr_i makes a still-active input re-arm when release drops.
  assign trig = act_i & ~clr_i;

  always_ff @(posedge trig or posedge clr_i) begin
    if (clr_i) hit_q <= 1'b0;
    else       hit_q <= 1'b1;
  end

  // Level term covers the release pulse window so no dip reaches the sync.
  assign status_o = hit_q | act_i;
endmodule

// File: rtl/lirq_sync2.sv
`timescale 1ns/1ps
module lirq_sync2 #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] stage1_o,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      out_q  <= '0;
    end else begin
      meta_q <= d_i;
      out_q  <= meta_q;
    end
  end

  assign stage1_o = meta_q;
  assign q_o      = out_q;
endmodule

// File: rtl/latch_irq_bank.sv
`timescale 1ns/1ps
module latch_irq_bank
  import lirq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] rdata_o,
  input  logic [NUM_CH-1:0] evt_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFF_MSK);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFF_POL);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);

  logic              wr_en;
  logic [NUM_CH-1:0] en_q, pol_q, clr_q;
  logic [NUM_CH-1:0] act, clr_async, cap_status;
  logic [NUM_CH-1:0] meta_w, raw_w, msk_w;

  assign wr_en = sel_i & wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pol_q <= '0;
      clr_q <= '0;
    end else begin
      clr_q <= (wr_en && addr_i == A_CLR) ? wdata_i : '0;
      if (wr_en && addr_i == A_EN)  en_q  <= wdata_i;
      if (wr_en && addr_i == A_POL) pol_q <= wdata_i;
    end
  end

  // pol 1 = active-low
  assign act       = evt_i ^ pol_q;
  assign clr_async = clr_q | {NUM_CH{~rst_ni}};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    lirq_catch_cell u_cell (
      .act_i    (act[i]),
      .clr_i    (clr_async[i]),
      .status_o (cap_status[i])
    );
  end

  lirq_sync2 #(.W(NUM_CH)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (cap_status),
    .stage1_o (meta_w),
    .q_o      (raw_w)
  );

  assign msk_w = raw_w & en_q;
  assign irq_o = |msk_w;

  always_comb begin
    unique case (addr_i)
      A_EN:    rdata_o = en_q;
      A_RAW:   rdata_o = raw_w;
      A_MSK:   rdata_o = msk_w;
      A_POL:   rdata_o = pol_q;
      A_MODE:  rdata_o = '1;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/latch_irq_bank_chk.sv
`timescale 1ns/1ps
module latch_irq_bank_chk
  import lirq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NUM_CH-1:0] rdata_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] pol_q,
  input logic [NUM_CH-1:0] meta_w,
  input logic [NUM_CH-1:0] raw_w
);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFF_MSK);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);

  assert_reset_cfg_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (en_q == '0 && pol_q == '0));

  assert_clr_keeps_cfg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == A_CLR) |=> ($stable(en_q) && $stable(pol_q)));

  assert_raw_via_stage_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_w & ~$past(raw_w) & ~$past(meta_w)) == '0));

  assert_masked_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && addr_i == A_MSK) |-> ((rdata_o & ~en_q) == '0));

  assert_irq_matches_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && addr_i == A_MSK) |-> ((|rdata_o) == irq_o));

  assert_mode_ones_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && addr_i == A_MODE) |-> (rdata_o == '1));
endmodule

bind latch_irq_bank latch_irq_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .en_q    (en_q),
  .pol_q   (pol_q),
  .meta_w  (meta_w),
  .raw_w   (raw_w)
);

// File: tb/latch_irq_bank_tb_top.sv
`timescale 1ns/1ps
module latch_irq_bank_tb_top;
  localparam int NC = 8;
  localparam int AW = 5;
  localparam logic [AW-1:0] EN = 5'h00, RAW = 5'h04, MSK = 5'h08,
                            CLR = 5'h0C, POL = 5'h10, MODE = 5'h14;

  logic          clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
  logic          sel = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NC-1:0] wdata = '0, evt = '0, rdata;
  logic          irq;
  int            n_chk = 0, n_fail = 0;

  latch_irq_bank #(.NUM_CH(NC), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  // 125 MHz, stoppable in the low phase
  initial forever begin
    #4;
    if (clk_run) clk = ~clk;
    else         clk = 1'b0;
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [AW-1:0] a, logic [NC-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  // call just after a negedge; consumes no clock edge
  task automatic rd_chk(string tag, logic [AW-1:0] a, logic [NC-1:0] exp);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    chk(tag, rdata, exp);
    sel = 1'b0;
  endtask

  task automatic do_reset();
    evt = '0; rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk("R1 enable", EN, '0);
    rd_chk("R1 polarity", POL, '0);
    rd_chk("R1 raw", RAW, '0);
    rd_chk("R1 masked", MSK, '0);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_readback();
    do_reset();
    wr_reg(EN, 8'h5A);
    rd_chk("R11 enable readback", EN, 8'h5A);
    evt = 8'hFF;
    wr_reg(POL, 8'hC3);
    rd_chk("R11 polarity readback", POL, 8'hC3);
  endtask

  task automatic t_sync_delay();
    do_reset();
    @(negedge clk);
    evt[0] = 1'b1;
    @(negedge clk);
    rd_chk("R7 not visible after one edge", RAW, '0);
    @(negedge clk);
    rd_chk("R7 visible after two edges", RAW, 8'h01);
  endtask

  task automatic t_active_high();
    do_reset();
    evt[1] = 1'b1;
    wait_n(3);
    rd_chk("R2 captured high", RAW, 8'h02);
    evt[1] = 1'b0;
    wait_n(3);
    rd_chk("R2 held after input low", RAW, 8'h02);
  endtask

  task automatic t_active_low();
    do_reset();
    wr_reg(POL, 8'h04);
    wait_n(3);
    rd_chk("R3 captured low level", RAW, 8'h04);
    evt[2] = 1'b1;
    wait_n(3);
    rd_chk("R3 held after input high", RAW, 8'h04);
    wr_reg(CLR, 8'h04);
    wait_n(3);
    rd_chk("R3 released when inactive", RAW, '0);
  endtask

  task automatic t_clear_select();
    do_reset();
    evt[1] = 1'b1; evt[4] = 1'b1;
    wait_n(1);
    evt = '0;
    wr_reg(EN, 8'hF0);
    wait_n(3);
    rd_chk("R5 both captured", RAW, 8'h12);
    wr_reg(CLR, 8'h00);
    wait_n(3);
    rd_chk("R5 zero write keeps captures", RAW, 8'h12);
    wr_reg(CLR, 8'h10);
    wait_n(3);
    rd_chk("R5 selective release", RAW, 8'h02);
    rd_chk("R5 enable unchanged", EN, 8'hF0);
  endtask

  task automatic t_clear_active();
    do_reset();
    evt[5] = 1'b1;
    wait_n(3);
    wr_reg(CLR, 8'h20);
    wait_n(3);
    rd_chk("R6 still set while active", RAW, 8'h20);
    evt[5] = 1'b0;
    wait_n(3);
    rd_chk("R6 re-set capture holds", RAW, 8'h20);
    wr_reg(CLR, 8'h20);
    wait_n(3);
    rd_chk("R6 release after inactive", RAW, '0);
  endtask

  task automatic t_mask_irq();
    do_reset();
    evt[1] = 1'b1; evt[6] = 1'b1;
    wait_n(1);
    evt = '0;
    wait_n(3);
    chk("R9 irq low with nothing enabled", irq, 1'b0);
    rd_chk("R8 masked with enable 0", MSK, '0);
    wr_reg(EN, 8'h40);
    rd_chk("R8 masked one channel", MSK, 8'h40);
    chk("R9 irq high", irq, 1'b1);
    wr_reg(EN, 8'h01);
    rd_chk("R8 masked no overlap", MSK, '0);
    chk("R9 irq low again", irq, 1'b0);
  endtask

  task automatic t_readonly();
    do_reset();
    evt[3] = 1'b1;
    wait_n(1);
    evt = '0;
    wait_n(3);
    wr_reg(RAW, 8'h00);
    wr_reg(MSK, 8'hFF);
    wr_reg(MODE, 8'h00);
    wait_n(3);
    rd_chk("R10 raw unaffected", RAW, 8'h08);
    rd_chk("R10 mode reads level", MODE, 8'hFF);
    rd_chk("R10 enable unaffected", EN, '0);
  endtask

  task automatic t_no_clock();
    do_reset();
    @(negedge clk);
    clk_run = 1'b0;
    #20;
    evt[3] = 1'b1;
    #2;
    evt[3] = 1'b0;
    #40;
    clk_run = 1'b1;
    wait_n(3);
    rd_chk("R4 captured with clock stopped", RAW, 8'h08);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running, expected done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_readback();
    t_sync_delay();
    t_active_high();
    t_active_low();
    t_clear_select();
    t_clear_active();
    t_mask_irq();
    t_readonly();
    t_no_clock();
    summary();
    $finish;
  end
endmodule